// File: doc/BRIEF.md
# Partitioned 8x16 Fractional Multiplier

This block is a pipelined SIMD multiplier for pixel-style arithmetic. Each lane multiplies an unsigned 8-bit component by a signed 16-bit coefficient. It keeps the middle sixteen bits of the product and rounds them up when the bit just below that window is set. An operation select picks one of seven variants. The variants differ in three ways: where the bytes come from in the first source, whether one shared coefficient or one coefficient per lane is used, and whether the output is four packed 16-bit lanes or two 32-bit words that hold a shifted 16-bit field.

A caller presents an operation, two 64-bit sources and a valid strobe in one cycle. The result appears with its own valid flag two clock edges later. A new operation may be issued on every cycle. The result register keeps its value until the next operation reaches it.

Top module: `frac_mul8x16`

## Requirements
- R1: Each lane forms the signed product of an unsigned 8-bit value and a signed 16-bit value. The lane result is product bits [23:8] plus product bit 7, wrapping within 16 bits, so a byte of 1 times a coefficient of -1 gives 0x0000.
- R2: Select code 0 (per-lane): byte n of src_a[31:0] multiplies src_b[16n+15:16n], and the result goes to out_result[16n+15:16n] for n = 0..3.
- R3: Select codes 1 and 2 (shared coefficient): byte n of src_a[31:0] multiplies one coefficient, which is src_b[31:16] for code 1 and src_b[15:0] for code 2. The result for byte n goes to 16-bit lane n.
- R4: Select codes 3 and 4 (byte-of-lane): lane n of src_a holds 16 bits. Code 3 uses bits [16n+15:16n+8] and code 4 uses bits [16n+7:16n], multiplied by src_b[16n+15:16n], with the result in 16-bit lane n.
- R5: Select codes 5 and 6 (widened): only lanes 0 and 1 are computed. The byte is the upper byte (code 5) or the lower byte (code 6) of src_a[16n+15:16n], and the coefficient is src_b[16n+15:16n]. The 16-bit result is placed at out_result[32n+22:32n+7], and every other output bit is 0.
- R6: Select code 7 is reserved. It produces an all-zero result, with out_valid asserted as for any other operation.
- R7: out_valid rises exactly two rising clock edges after the edge that samples in_valid high. Back-to-back operations come out in order, one per cycle.
- R8: When no operation completes in a cycle, out_result keeps its previous value, whatever the sources and the select are doing.
- R9: While reset is asserted, out_valid is 0 and out_result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operation strobe; sources and select are sampled when high |
| op_sel | input | 3 | Variant select, codes 0 to 7 as in R2 to R6 |
| src_a | input | 64 | First source: the byte operands |
| src_b | input | 64 | Second source: the coefficients |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Packed lane results |

## Verification
The embedded assertions check, on every cycle, that valid flows through the two stages with no loss or spurious pulse, that the result register holds when no operation completes, that a reserved operation yields zero, that the gaps around the widened fields stay zero, and that a zero byte gives a zero product in its lane. Whether the correct bytes and coefficients reach each lane and whether the rounding value is right can only be shown by the bench. It compares every result against an independent model. The stimulus is random operands in all eight select codes, plus directed corners: the wrap-around rounding case, the most negative coefficient, the full-scale byte, and garbage in the unused upper source bits.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  parameter int FM_LANES  = 4;
  parameter int FM_BYTE_W = 8;
  parameter int FM_COEF_W = 16;
  parameter int FM_DATA_W = FM_LANES * FM_COEF_W;

  typedef enum logic [2:0] {
    FM_PER_LANE  = 3'd0,
    FM_SHARED_HI = 3'd1,
    FM_SHARED_LO = 3'd2,
    FM_UPPER_B   = 3'd3,
    FM_LOWER_B   = 3'd4,
    FM_WIDE_UP   = 3'd5,
    FM_WIDE_LO   = 3'd6,
    FM_RESERVED  = 3'd7
  } fm_mode_e;
endpackage

// File: rtl/fmul_rst_sync.sv
module fmul_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/fmul_operand_sel.sv
module fmul_operand_sel
  import fmul_pkg::*;
#(
  parameter int LANES  = FM_LANES,
  parameter int BYTE_W = FM_BYTE_W,
  parameter int COEF_W = FM_COEF_W,
  localparam int DATA_W = LANES * COEF_W,
  localparam int WIDE_LANES = LANES / 2
) (
  input  fm_mode_e                       mode_i,
  input  logic [DATA_W-1:0]              a_i,
  input  logic [DATA_W-1:0]              b_i,
  output logic [LANES-1:0][BYTE_W-1:0]   byte_o,
  output logic [LANES-1:0][COEF_W-1:0]   coef_o
);
  logic [COEF_W-1:0] shared_hi;
  logic [COEF_W-1:0] shared_lo;

  assign shared_hi = b_i[2*COEF_W-1 -: COEF_W];
  assign shared_lo = b_i[COEF_W-1:0];

  always_comb begin
    for (int n = 0; n < LANES; n++) begin
      byte_o[n] = '0;
      coef_o[n] = '0;
      unique case (mode_i)
        FM_PER_LANE: begin
          byte_o[n] = a_i[n*BYTE_W +: BYTE_W];
          coef_o[n] = b_i[n*COEF_W +: COEF_W];
        end
        FM_SHARED_HI: begin
          byte_o[n] = a_i[n*BYTE_W +: BYTE_W];
          coef_o[n] = shared_hi;
        end
        FM_SHARED_LO: begin
          byte_o[n] = a_i[n*BYTE_W +: BYTE_W];
          coef_o[n] = shared_lo;
        end
        FM_UPPER_B: begin
          byte_o[n] = a_i[n*COEF_W + COEF_W - 1 -: BYTE_W];
          coef_o[n] = b_i[n*COEF_W +: COEF_W];
        end
        FM_LOWER_B: begin
          byte_o[n] = a_i[n*COEF_W +: BYTE_W];
          coef_o[n] = b_i[n*COEF_W +: COEF_W];
        end
        FM_WIDE_UP: begin
          if (n < WIDE_LANES) begin
            byte_o[n] = a_i[n*COEF_W + COEF_W - 1 -: BYTE_W];
            coef_o[n] = b_i[n*COEF_W +: COEF_W];
          end
        end
        FM_WIDE_LO: begin
          if (n < WIDE_LANES) begin
            byte_o[n] = a_i[n*COEF_W +: BYTE_W];
            coef_o[n] = b_i[n*COEF_W +: COEF_W];
          end
        end
        default: begin
          byte_o[n] = '0;
          coef_o[n] = '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/fmul_lane.sv
module fmul_lane #(
  parameter int BYTE_W = 8,
  parameter int COEF_W = 16,
  localparam int PROD_W = BYTE_W + COEF_W + 1,
  localparam int KEEP_W = COEF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic [KEEP_W-1:0] keep_q
);
  logic signed [PROD_W-1:0] prod;
  logic [KEEP_W-1:0]        keep_d;
  logic                     lane_unused;

  always_comb begin
    prod   = $signed({1'b0, byte_i}) * $signed(coef_i);
    keep_d = keep_q;
    if (en) begin
      keep_d = prod[BYTE_W+COEF_W-1 : BYTE_W-1];
    end
  end

  assign lane_unused = ^{prod[PROD_W-1], prod[BYTE_W-2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_q <= '0;
    end else begin
      keep_q <= keep_d;
    end
  end

  AST_ZERO_BYTE_ZERO_PROD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && byte_i == '0) |=> (keep_q == '0)); // R1
endmodule

// File: rtl/fmul_round_place.sv
module fmul_round_place
  import fmul_pkg::*;
#(
  parameter int LANES  = FM_LANES,
  parameter int BYTE_W = FM_BYTE_W,
  parameter int COEF_W = FM_COEF_W,
  localparam int DATA_W = LANES * COEF_W,
  localparam int KEEP_W = COEF_W + 1,
  localparam int WIDE_LANES = LANES / 2,
  localparam int WIDE_OFS = BYTE_W - 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  fm_mode_e                      mode_i,
  input  logic [LANES-1:0][KEEP_W-1:0]  keep_i,
  output logic [DATA_W-1:0]             result_q
);
  function automatic logic [DATA_W-1:0] wide_fields();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int n = 0; n < WIDE_LANES; n++) begin
      m[n*2*COEF_W + WIDE_OFS +: COEF_W] = '1;
    end
    return m;
  endfunction

  localparam logic [DATA_W-1:0] WIDE_MASK = wide_fields();

  logic [LANES-1:0][COEF_W-1:0] scaled;
  logic [DATA_W-1:0]            placed;
  logic [DATA_W-1:0]            result_d;

  always_comb begin
    for (int n = 0; n < LANES; n++) begin
      scaled[n] = keep_i[n][KEEP_W-1:1] + {{(COEF_W-1){1'b0}}, keep_i[n][0]};
    end
  end

  always_comb begin
    placed = '0;
    unique case (mode_i)
      FM_RESERVED: placed = '0;
      FM_WIDE_UP, FM_WIDE_LO: begin
        for (int n = 0; n < WIDE_LANES; n++) begin
          placed[n*2*COEF_W + WIDE_OFS +: COEF_W] = scaled[n];
        end
      end
      default: begin
        for (int n = 0; n < LANES; n++) begin
          placed[n*COEF_W +: COEF_W] = scaled[n];
        end
      end
    endcase
  end

  always_comb begin
    result_d = result_q;
    if (en) begin
      result_d = placed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else begin
      result_q <= result_d;
    end
  end

  AST_WIDE_GAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (mode_i == FM_WIDE_UP || mode_i == FM_WIDE_LO))
      |=> ((result_q & ~WIDE_MASK) == '0)); // R5
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode_i == FM_RESERVED) |=> (result_q == '0)); // R6
endmodule

// File: rtl/frac_mul8x16.sv
module frac_mul8x16
  import fmul_pkg::*;
#(
  parameter int LANES  = FM_LANES,
  parameter int BYTE_W = FM_BYTE_W,
  parameter int COEF_W = FM_COEF_W,
  localparam int DATA_W = LANES * COEF_W,
  localparam int KEEP_W = COEF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result
);
  logic                          rst_sync_n;
  fm_mode_e                      in_mode;
  logic [LANES-1:0][BYTE_W-1:0]  lane_byte;
  logic [LANES-1:0][COEF_W-1:0]  lane_coef;
  logic [LANES-1:0][KEEP_W-1:0]  lane_keep;

  logic     s1_valid_q, s1_valid_d;
  fm_mode_e s1_mode_q,  s1_mode_d;
  logic     out_valid_q, out_valid_d;

  assign in_mode = fm_mode_e'(op_sel);

  fmul_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fmul_operand_sel #(
    .LANES  (LANES),
    .BYTE_W (BYTE_W),
    .COEF_W (COEF_W)
  ) u_sel (
    .mode_i (in_mode),
    .a_i    (src_a),
    .b_i    (src_b),
    .byte_o (lane_byte),
    .coef_o (lane_coef)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fmul_lane #(
      .BYTE_W (BYTE_W),
      .COEF_W (COEF_W)
    ) u_lane (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .en     (in_valid),
      .byte_i (lane_byte[g]),
      .coef_i (lane_coef[g]),
      .keep_q (lane_keep[g])
    );
  end

  always_comb begin
    s1_valid_d  = in_valid;
    s1_mode_d   = s1_mode_q;
    if (in_valid) begin
      s1_mode_d = in_mode;
    end
    out_valid_d = s1_valid_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_valid_q  <= 1'b0;
      s1_mode_q   <= FM_PER_LANE;
      out_valid_q <= 1'b0;
    end else begin
      s1_valid_q  <= s1_valid_d;
      s1_mode_q   <= s1_mode_d;
      out_valid_q <= out_valid_d;
    end
  end

  fmul_round_place #(
    .LANES  (LANES),
    .BYTE_W (BYTE_W),
    .COEF_W (COEF_W)
  ) u_round (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (s1_valid_q),
    .mode_i   (s1_mode_q),
    .keep_i   (lane_keep),
    .result_q (out_result)
  );

  assign out_valid = out_valid_q;

  AST_S1_FOLLOWS_IN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> s1_valid_q); // R7
  AST_OUT_FOLLOWS_S1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    s1_valid_q |=> out_valid); // R7
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !s1_valid_q |=> !out_valid); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !s1_valid_q |=> $stable(out_result)); // R8
endmodule

// File: tb/tb_frac_mul8x16.sv
module tb_frac_mul8x16;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op_sel;
  logic [63:0] src_a;
  logic [63:0] src_b;
  logic        out_valid;
  logic [63:0] out_result;

  int total;
  int bad;
  bit done;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] last_res;

  frac_mul8x16 dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_sel     (op_sel),
    .src_a      (src_a),
    .src_b      (src_b),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] lane_ref(input logic [7:0] x, input logic [15:0] c);
    logic signed [24:0] p;
    p = $signed({1'b0, x}) * $signed(c);
    return p[23:8] + {15'd0, p[7]};
  endfunction

  function automatic logic [63:0] ref_model(input logic [2:0] m, input logic [63:0] a,
                                            input logic [63:0] b);
    logic [63:0] r;
    r = '0;
    case (m)
      3'd0: for (int n = 0; n < 4; n++) r[16*n +: 16] = lane_ref(a[8*n +: 8], b[16*n +: 16]);
      3'd1: for (int n = 0; n < 4; n++) r[16*n +: 16] = lane_ref(a[8*n +: 8], b[31:16]);
      3'd2: for (int n = 0; n < 4; n++) r[16*n +: 16] = lane_ref(a[8*n +: 8], b[15:0]);
      3'd3: for (int n = 0; n < 4; n++) r[16*n +: 16] = lane_ref(a[16*n+8 +: 8], b[16*n +: 16]);
      3'd4: for (int n = 0; n < 4; n++) r[16*n +: 16] = lane_ref(a[16*n +: 8], b[16*n +: 16]);
      3'd5: for (int n = 0; n < 2; n++) r[32*n+7 +: 16] = lane_ref(a[16*n+8 +: 8], b[16*n +: 16]);
      3'd6: for (int n = 0; n < 2; n++) r[32*n+7 +: 16] = lane_ref(a[16*n +: 8], b[16*n +: 16]);
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1, 3'd2: return "R3";
      3'd3, 3'd4: return "R4";
      3'd5, 3'd6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] m, input logic [63:0] a, input logic [63:0] b,
                      input string req);
    @(negedge clk);
    in_valid = 1'b1;
    op_sel   = m;
    src_a    = a;
    src_b    = b;
    exp_q.push_back(ref_model(m, a, b));
    tag_q.push_back(req);
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_sel   = 3'($urandom);
      src_a    = {$urandom, $urandom};
      src_b    = {$urandom, $urandom};
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected", out_result, 64'd0);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_result === e, t, out_result, e);
      end
      last_res = out_result;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 0;
    rst_n = 1'b0; in_valid = 1'b0; op_sel = '0; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid === 1'b0, "R9", {63'd0, out_valid}, 64'd0);
    check(out_result === 64'd0, "R9", out_result, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: rounding corners (wrap, half-up, below half, most negative coef)
    send(3'd0, 64'h0000_0000_ff7f_8001, 64'h8000_0001_0001_ffff, "R1");
    send(3'd0, 64'hdead_beef_01ff_ff01, 64'hffff_7fff_8000_ffff, "R1");
    send(3'd2, 64'hffff_ffff_0201_80ff, 64'h1234_5678_9abc_ffff, "R1");
    idle(1);
    check(out_valid === 1'b1, "R7 back-to-back", {63'd0, out_valid}, 64'd1);
    idle(4);

    // R7: latency of exactly two edges
    send(3'd1, 64'h0000_0000_1020_3040, 64'h0000_0000_4000_0000, "R3");
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b0, "R7 early", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    check(out_valid === 1'b1, "R7 on time", {63'd0, out_valid}, 64'd1);
    idle(3);

    // random sweep across every select code, with gaps
    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < 24; k++) begin
        logic [63:0] a;
        logic [63:0] b;
        a = {$urandom, $urandom};
        b = {$urandom, $urandom};
        if (k == 0) b[15:0] = 16'h8000;
        if (k == 1) a = 64'hffff_ffff_ffff_ffff;
        send(3'(m), a, b, tag_of(3'(m)));
        if ((k % 5) == 4) idle(1);
      end
    end
    idle(4);

    // R8: result holds while inputs change with no operation
    send(3'd4, 64'h0000_0000_0077_0033, 64'h0000_0000_0123_0456, "R4");
    idle(3);
    for (int i = 0; i < 6; i++) begin
      idle(1);
      check(out_result === last_res, "R8", out_result, last_res);
    end
    check(exp_q.size() == 0, "R7 drained", 64'(exp_q.size()), 64'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule